// File: doc/BRIEF.md
# Dual-Slope Converter Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It runs from the oscillator clock and divides that clock down to a count rate. It steps through three mutually exclusive phases: offset nulling, input integration for a fixed number of counts, and reference run-down. It drives one enable strobe for each phase and a direction select for the reference. The run-down lasts until the single-bit comparator input reports that the integrator has crossed back through zero. Offset nulling then takes up the counts that run-down did not use, so every conversion has the same length.

During run-down a chain of decimal decades counts. When run-down ends, the count, the input polarity and an overrange flag are copied into a display latch. The latch holds those values unchanged through the whole following conversion. If the comparator never trips, run-down is cut off at full scale and the latch receives a fixed overrange pattern.

Top module: `dsadc_sequencer`

## Requirements
- R1: While reset is asserted, the offset-null strobe is high, the other two strobes are low, and the latched digits, polarity and overrange flag are all zero.
- R2: Exactly one phase strobe is high at any time. The phases always run in the order offset-null, integrate, run-down, and then back to offset-null.
- R3: The integrate strobe stays high for exactly INT_COUNTS × PRESCALE clocks. One count is PRESCALE oscillator clocks.
- R4: The comparator level seen at the last count of integration is the polarity (1 = negative input). It drives `ref_sel_o` throughout run-down and is latched into `rd_neg_o`.
- R5: Run-down ends at the first count at which the comparator differs from the stored polarity. The comparator is examined once per count. If this happens after k whole counts, run-down lasts (k+1) × PRESCALE clocks and the latched reading is k with `rd_ovr_o` low.
- R6: The reading is decimal. Nibble i (bits 4i+3..4i) holds decade i, with i = 0 as the units. Each decade rolls from 9 to 0 and carries into the next decade.
- R7: If no trip occurs within DEINT_MAX counts, run-down lasts DEINT_MAX × PRESCALE clocks. In that case `rd_ovr_o` is set and the digits take the overrange pattern: the top nibble is 1 and every other nibble is 4'hF.
- R8: A trip at the final permitted count (k = DEINT_MAX − 1) takes precedence over the forced end. The reading is then DEINT_MAX − 1, not overrange.
- R9: Successive rising edges of the integrate strobe are always exactly CYCLE_COUNTS × PRESCALE clocks apart, whatever the input.
- R10: The latched digits, polarity and flag change only on the clock that ends run-down. They stay stable through the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator output, 1 when the integrator is above zero |
| az_en_o | output | 1 | Offset-null phase switch strobe |
| int_en_o | output | 1 | Input-integrate phase switch strobe |
| deint_en_o | output | 1 | Reference run-down phase switch strobe |
| ref_sel_o | output | 1 | Reference direction for run-down (1 = negative input) |
| rd_digits_o | output | 4×DIGITS | Latched decimal reading, units in the low nibble |
| rd_neg_o | output | 1 | Latched polarity |
| rd_ovr_o | output | 1 | Latched overrange flag |

## Verification
Two events can fall on the same count: a comparator trip and the full-scale cut-off of run-down. Both arrive on the count at which the counter reaches DEINT_MAX − 1. The bench provokes this by flipping the comparator exactly PRESCALE × (DEINT_MAX − 1) clocks after run-down starts. It judges the result by requiring the non-overrange reading DEINT_MAX − 1 with the same run-down length as a forced end. A second collision, between the trip and the first run-down count, is driven with k = 0.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;

  // one decade step: 9 wraps to 0
  function automatic logic [3:0] bcd_step(input logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  // counts left for offset nulling once integrate and run-down are spent
  function automatic int unsigned az_counts(input int unsigned cycle,
                                            input int unsigned integ,
                                            input int unsigned used);
    return cycle - integ - used;
  endfunction

endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      div_q <= '0;
    else if (div_q == PW'(PRESCALE - 1))
      div_q <= '0;
    else
      div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == PW'(PRESCALE - 1));
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
  import dsadc_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   value_o
);
  logic [DIGITS:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_decade
    logic [3:0] dec_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        dec_q <= 4'd0;
      else if (clr_i)
        dec_q <= 4'd0;
      else if (carry[g])
        dec_q <= bcd_step(dec_q);
    end

    assign carry[g+1]        = carry[g] && (dec_q == 4'd9);
    assign value_o[4*g +: 4] = dec_q;
  end
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
  import dsadc_pkg::*;
#(
  parameter int unsigned INT_COUNTS   = 1000,
  parameter int unsigned DEINT_MAX    = 2000,
  parameter int unsigned CYCLE_COUNTS = 4000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   cmp_i,
  output phase_e phase_o,
  output logic   pol_o,
  output logic   int_end_o,
  output logic   deint_trip_o,
  output logic   deint_force_o,
  output logic   bcd_clr_o,
  output logic   bcd_inc_o
);
  localparam int unsigned CNT_W = $clog2(CYCLE_COUNTS + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] used_q;
  logic             pol_q;
  logic [CNT_W-1:0] az_last;
  logic             az_end;
  logic             deint_exit;

  assign az_last = CNT_W'(az_counts(CYCLE_COUNTS, INT_COUNTS, int'(used_q)) - 1);

  assign az_end        = tick_i && (phase_q == PH_AZ)  && (pcnt_q == az_last);
  assign int_end_o     = tick_i && (phase_q == PH_INT) && (pcnt_q == CNT_W'(INT_COUNTS - 1));
  assign deint_trip_o  = tick_i && (phase_q == PH_DEINT) && (cmp_i != pol_q);
  assign deint_force_o = tick_i && (phase_q == PH_DEINT) && (cmp_i == pol_q)
                         && (pcnt_q == CNT_W'(DEINT_MAX - 1));
  assign deint_exit    = deint_trip_o || deint_force_o;
  assign bcd_clr_o     = int_end_o;
  assign bcd_inc_o     = tick_i && (phase_q == PH_DEINT) && (cmp_i == pol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_AZ;
      pcnt_q  <= '0;
      used_q  <= '0;
      pol_q   <= 1'b0;
    end else if (tick_i) begin
      unique case (phase_q)
        PH_AZ: begin
          if (az_end) begin
            phase_q <= PH_INT;
            pcnt_q  <= '0;
          end else begin
            pcnt_q  <= pcnt_q + 1'b1;
          end
        end
        PH_INT: begin
          if (int_end_o) begin
            phase_q <= PH_DEINT;
            pcnt_q  <= '0;
            pol_q   <= cmp_i;
          end else begin
            pcnt_q  <= pcnt_q + 1'b1;
          end
        end
        PH_DEINT: begin
          if (deint_exit) begin
            phase_q <= PH_AZ;
            pcnt_q  <= '0;
            used_q  <= pcnt_q + 1'b1;
          end else begin
            pcnt_q  <= pcnt_q + 1'b1;
          end
        end
        default: begin
          phase_q <= PH_AZ;
          pcnt_q  <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign pol_o   = pol_q;
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
  import dsadc_pkg::*;
#(
  parameter int unsigned PRESCALE     = 4,
  parameter int unsigned INT_COUNTS   = 1000,
  parameter int unsigned DEINT_MAX    = 2000,
  parameter int unsigned CYCLE_COUNTS = 4000,
  parameter int unsigned DIGITS       = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmp_i,
  output logic                az_en_o,
  output logic                int_en_o,
  output logic                deint_en_o,
  output logic                ref_sel_o,
  output logic [4*DIGITS-1:0] rd_digits_o,
  output logic                rd_neg_o,
  output logic                rd_ovr_o
);
  localparam int unsigned DW = 4 * DIGITS;

  logic          tick;
  phase_e        phase;
  logic          pol;
  logic          int_end;
  logic          deint_trip;
  logic          deint_force;
  logic          conv_latch;
  logic          bcd_clr;
  logic          bcd_inc;
  logic [DW-1:0] bcd_val;
  logic [DW-1:0] ovr_code;

  dsadc_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  dsadc_phase_ctrl #(
    .INT_COUNTS   (INT_COUNTS),
    .DEINT_MAX    (DEINT_MAX),
    .CYCLE_COUNTS (CYCLE_COUNTS)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (tick),
    .cmp_i         (cmp_i),
    .phase_o       (phase),
    .pol_o         (pol),
    .int_end_o     (int_end),
    .deint_trip_o  (deint_trip),
    .deint_force_o (deint_force),
    .bcd_clr_o     (bcd_clr),
    .bcd_inc_o     (bcd_inc)
  );

  dsadc_bcd_counter #(.DIGITS(DIGITS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (bcd_clr),
    .inc_i   (bcd_inc),
    .value_o (bcd_val)
  );

  for (genvar g = 0; g < DIGITS; g++) begin : g_ovr
    if (g == DIGITS - 1) begin : g_top
      assign ovr_code[4*g +: 4] = 4'h1;
    end else begin : g_low
      assign ovr_code[4*g +: 4] = 4'hF;
    end
  end

  assign conv_latch = deint_trip || deint_force;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_digits_o <= '0;
      rd_neg_o    <= 1'b0;
      rd_ovr_o    <= 1'b0;
    end else if (conv_latch) begin
      rd_neg_o    <= pol;
      rd_ovr_o    <= deint_force;
      rd_digits_o <= deint_force ? ovr_code : bcd_val;
    end
  end

  assign az_en_o    = (phase == PH_AZ);
  assign int_en_o   = (phase == PH_INT);
  assign deint_en_o = (phase == PH_DEINT);
  assign ref_sel_o  = pol;

  // int_end is observed only through the phase change it causes
  logic unused_evt;
  assign unused_evt = int_end;
endmodule

// File: rtl/dsadc_sequencer_chk.sv
module dsadc_sequencer_chk #(
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned INT_COUNTS = 1000,
  parameter int unsigned DIGITS     = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick,
  input logic                az_en_o,
  input logic                int_en_o,
  input logic                deint_en_o,
  input logic                ref_sel_o,
  input logic [4*DIGITS-1:0] rd_digits_o,
  input logic                rd_ovr_o,
  input logic                deint_trip,
  input logic                conv_latch
);
  int unsigned int_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       int_run <= 0;
    else if (int_en_o) int_run <= int_run + 1;
    else               int_run <= 0;
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({az_en_o, int_en_o, deint_en_o}) == 1);

  p_int_to_deint_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_en_o) |-> deint_en_o);

  p_deint_to_az_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(deint_en_o) |-> az_en_o);

  p_az_to_int_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(az_en_o) |-> int_en_o);

  p_int_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_en_o) |-> (int_run == PRESCALE * INT_COUNTS));

  p_ref_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deint_en_o && $past(deint_en_o)) |-> $stable(ref_sel_o));

  p_ovr_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ovr_o |-> (rd_digits_o[4*DIGITS-1 -: 4] == 4'h1 &&
                  (DIGITS < 2 || rd_digits_o[3:0] == 4'hF)));

  p_trip_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deint_trip |=> !rd_ovr_o);

  p_latch_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_latch |=> $stable(rd_digits_o) && $stable(rd_ovr_o));

  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PRESCALE > 1 && tick) |=> !tick);
endmodule

bind dsadc_sequencer dsadc_sequencer_chk #(
  .PRESCALE   (PRESCALE),
  .INT_COUNTS (INT_COUNTS),
  .DIGITS     (DIGITS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick        (tick),
  .az_en_o     (az_en_o),
  .int_en_o    (int_en_o),
  .deint_en_o  (deint_en_o),
  .ref_sel_o   (ref_sel_o),
  .rd_digits_o (rd_digits_o),
  .rd_ovr_o    (rd_ovr_o),
  .deint_trip  (deint_trip),
  .conv_latch  (conv_latch)
);

// File: tb/dsadc_sequencer_tb.sv
module dsadc_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PS   = 4;
  localparam int IC   = 50;
  localparam int DM   = 1200;
  localparam int CC   = 1300;
  localparam int DG   = 4;
  localparam int DW   = 4 * DG;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp;
  logic          az_en, int_en, deint_en, ref_sel, rd_neg, rd_ovr;
  logic [DW-1:0] rd_digits;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsadc_sequencer #(
    .PRESCALE(PS), .INT_COUNTS(IC), .DEINT_MAX(DM),
    .CYCLE_COUNTS(CC), .DIGITS(DG)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmp_i(cmp),
    .az_en_o(az_en), .int_en_o(int_en), .deint_en_o(deint_en),
    .ref_sel_o(ref_sel), .rd_digits_o(rd_digits),
    .rd_neg_o(rd_neg), .rd_ovr_o(rd_ovr)
  );

  function automatic logic [DW-1:0] to_dec(input int v);
    logic [DW-1:0] r = '0;
    int t = v;
    for (int i = 0; i < DG; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] ovr_pat();
    logic [DW-1:0] r = '1;
    r[DW-1 -: 4] = 4'h1;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0] exp_dig  = '0;
  logic          exp_neg  = 1'b0;
  logic          exp_ovr  = 1'b0;
  int            last_int = -1;

  // k < 0 means the comparator never trips
  task automatic run_conv(input int k, input bit neg);
    int n;
    int m;
    int occ;
    while (!int_en) @(negedge clk);
    if (last_int >= 0)
      check(cyc - last_int == CC * PS, "R9 period", cyc - last_int, CC * PS);
    last_int = cyc;
    check(rd_digits == exp_dig && rd_neg == exp_neg && rd_ovr == exp_ovr,
          "R10 hold", {rd_ovr, rd_neg, rd_digits}, {exp_ovr, exp_neg, exp_dig});
    cmp = neg;
    n = 0;
    while (int_en) begin n++; @(negedge clk); end
    check(n == IC * PS, "R3 integrate length", n, IC * PS);
    check(deint_en && !az_en && !int_en, "R2 order int->deint", {az_en, int_en, deint_en}, 3'b001);
    check(ref_sel == neg, "R4 ref select", ref_sel, neg);
    m = 0;
    while (deint_en) begin
      if (k >= 0 && m == PS * k) cmp = !neg;
      m++;
      @(negedge clk);
    end
    occ = (k >= 0) ? (k + 1) * PS : DM * PS;
    check(m == occ, k >= 0 ? "R5 rundown length" : "R7 forced length", m, occ);
    check(az_en && !int_en && !deint_en, "R2 order deint->az", {az_en, int_en, deint_en}, 3'b100);
    exp_neg = neg;
    if (k >= 0) begin
      exp_dig = to_dec(k);
      exp_ovr = 1'b0;
      check(rd_digits == exp_dig && !rd_ovr,
            (k == DM - 1) ? "R8 trip at last count" : "R5/R6 reading",
            {rd_ovr, rd_digits}, {1'b0, exp_dig});
    end else begin
      exp_dig = ovr_pat();
      exp_ovr = 1'b1;
      check(rd_digits == exp_dig && rd_ovr, "R7 overrange", {rd_ovr, rd_digits}, {1'b1, exp_dig});
    end
    check(rd_neg == neg, "R4 latched polarity", rd_neg, neg);
    cmp = 1'($urandom);
  endtask

  initial begin
    int seed;
    seed = $urandom(1234);
    rst_n = 1'b0;
    cmp   = 1'b0;
    repeat (3) @(negedge clk);
    check(az_en && !int_en && !deint_en, "R1 reset strobes", {az_en, int_en, deint_en}, 3'b100);
    check(rd_digits == '0 && !rd_neg && !rd_ovr, "R1 reset reading",
          {rd_ovr, rd_neg, rd_digits}, 0);
    rst_n = 1'b1;
    // directed: decade rollovers (R6), first-count trip, last-count collision (R8), overrange (R7)
    run_conv(0, 1'b0);
    run_conv(9, 1'b1);
    run_conv(10, 1'b0);
    run_conv(100, 1'b1);
    run_conv(1000, 1'b0);
    run_conv(DM - 1, 1'b1);
    run_conv(-1, 1'b0);
    run_conv(-1, 1'b1);
    run_conv(999, 1'b0);
    for (int i = 0; i < 10; i++) begin
      int r;
      r = int'($urandom % (DM + 150));
      run_conv((r >= DM) ? -1 : r, 1'($urandom));
    end
    run_conv(5, 1'b0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule